// File: doc/BRIEF.md
# One-Way Serial Link Transmit Framer

This block is the control engine of a transmit-only serial link that feeds an FPGA receiver over a lightweight 8b/10b protocol. The receiver cannot answer. Every step of link bring-up is therefore timed by local counters and never acknowledged. After reset the block emits a quiet pattern through two counted reset-hold stages. It then sends a fixed run of comma-bearing sync characters so that the receiver can lock its clock and word alignment. After that it carries packets for as long as it runs.

Payload bytes come from a first-word-fall-through FIFO. The FIFO shows an empty flag, the head byte and a flag that marks the last byte of a packet. The block wraps each packet in start and end control characters. It fills every gap with idle characters, both between packets and inside a packet that has run dry. On a fixed character schedule it sends a burst of clock-compensation characters. Such a burst pauses a packet in progress, and the packet then resumes with no byte lost or repeated. Each cycle the block gives one 8-bit character and a flag that marks it as a control (K) character for the 8b/10b encoder that follows.

Top module: `sertx_framer`

## Requirements
- R1: After reset is released, the first 1 + (LANES+2) + 3 characters are the quiet data character 0x00 with the K flag clear. The phase order is reset, lane hold, reset hold, sync, run, and it never goes backwards.
- R2: The quiet characters are followed by exactly SYNC_LEN sync characters 0xBC with K set. The link then stays in the run phase until the next reset.
- R3: In the run phase, with no packet open and the FIFO empty, each character is the idle 0xBC with K set.
- R4: A packet opens with the start character 0xFB with K set. This character is sent when the FIFO is not empty, and no FIFO read takes place in that cycle.
- R5: Each payload byte goes out in FIFO order with K clear, in the cycle in which fifo_rd pops it. Each byte is read exactly once.
- R6: The character after a byte flagged last is the end character 0xFD with K set. A compensation burst may come first, and in that case the end character follows the burst.
- R7: Inside an open packet, an empty FIFO produces idle 0xBC with K set. The packet then continues with no second start character.
- R8: Count run-phase characters from 0. Character k is the compensation character 0xFC with K set when (k mod (CC_PERIOD+CC_LEN)) >= CC_PERIOD, so each burst is CC_LEN characters long.
- R9: A compensation burst may fall inside a packet. It pauses the packet without losing or repeating any byte. fifo_rd stays low during quiet, sync, idle, start, end and compensation characters, and it is never high while the FIFO is empty.
- R10: While rst_n is low, tx_char is 0x00, tx_is_k is 0 and fifo_rd is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_empty | input | 1 | Payload FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the payload FIFO |
| fifo_last | input | 1 | Head byte is the last byte of its packet |
| fifo_rd | output | 1 | Pops the head byte at this clock edge |
| tx_char | output | 8 | Character to the 8b/10b encoder |
| tx_is_k | output | 1 | Character is a control (K) character |

## Verification
The bench uses a small configuration and predicts every output character, K flag and read strobe of the whole bring-up and run, using modulo arithmetic for the compensation schedule. The FIFO is first left empty, so idle fill shows up apart from framing. A batch of packets from one to forty bytes long then tells start, data and end characters apart. One of these packets is longer than a compensation period, so a burst must land inside it and show that the pause and resume work. A second batch is fed with the FIFO stalling in a periodic pattern. This exposes idle fill inside an open packet and shows whether a read happens while the FIFO is empty.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam logic [7:0] CH_QUIET = 8'h00;  // D0.0
  localparam logic [7:0] CH_IDLE  = 8'hBC;  // K28.5 comma, idle and sync
  localparam logic [7:0] CH_COMP  = 8'hFC;  // K28.7 clock compensation
  localparam logic [7:0] CH_SOF   = 8'hFB;  // K27.7 start of packet
  localparam logic [7:0] CH_EOF   = 8'hFD;  // K29.7 end of packet

  typedef enum logic [2:0] {
    PH_RST       = 3'd0,
    PH_HOLD_LANE = 3'd1,
    PH_HOLD_RST  = 3'd2,
    PH_SYNC      = 3'd3,
    PH_RUN       = 3'd4
  } phase_t;
endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/sertx_init_seq.sv
module sertx_init_seq
  import sertx_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int RST_HOLD = 3,
  parameter int SYNC_LEN = 128
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);
  localparam int LANE_HOLD = LANES + 2;
  localparam int MAX_A     = (LANE_HOLD > RST_HOLD) ? LANE_HOLD : RST_HOLD;
  localparam int MAX_CNT   = (MAX_A > SYNC_LEN) ? MAX_A : SYNC_LEN;
  localparam int CW        = $clog2(MAX_CNT + 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CW'(1);
    unique case (phase_q)
      PH_RST: begin
        phase_d = PH_HOLD_LANE;
        cnt_d   = '0;
      end
      PH_HOLD_LANE: if (cnt_q == CW'(LANE_HOLD - 1)) begin
        phase_d = PH_HOLD_RST;
        cnt_d   = '0;
      end
      PH_HOLD_RST: if (cnt_q == CW'(RST_HOLD - 1)) begin
        phase_d = PH_SYNC;
        cnt_d   = '0;
      end
      PH_SYNC: if (cnt_q == CW'(SYNC_LEN - 1)) begin
        phase_d = PH_RUN;
        cnt_d   = '0;
      end
      default: begin
        phase_d = PH_RUN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RST;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

  // R1
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> (3'(phase_q) == 3'($past(phase_q)) + 3'd1));

  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |=> (phase_q == PH_RUN));
endmodule

// File: rtl/sertx_cc_timer.sv
module sertx_cc_timer #(
  parameter int PERIOD = 5000,
  parameter int BURST  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cc_now
);
  localparam int PW = $clog2(PERIOD + 1);
  localparam int BW = $clog2(BURST + 1);

  logic          burst_q, burst_d;
  logic [PW-1:0] per_q, per_d;
  logic [BW-1:0] bcnt_q, bcnt_d;

  always_comb begin
    burst_d = burst_q;
    per_d   = per_q;
    bcnt_d  = bcnt_q;
    if (run) begin
      if (!burst_q) begin
        if (per_q == PW'(PERIOD - 1)) begin
          burst_d = 1'b1;
          per_d   = '0;
        end else begin
          per_d = per_q + PW'(1);
        end
      end else begin
        if (bcnt_q == BW'(BURST - 1)) begin
          burst_d = 1'b0;
          bcnt_d  = '0;
        end else begin
          bcnt_d = bcnt_q + BW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      per_q   <= '0;
      bcnt_q  <= '0;
    end else begin
      burst_q <= burst_d;
      per_q   <= per_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign cc_now = burst_q;

  // R8
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_q) |-> ($past(bcnt_q) == BW'(BURST - 1)));

  // R8
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_q) |-> ($past(per_q) == PW'(PERIOD - 1)));
endmodule

// File: rtl/sertx_frame_mux.sv
module sertx_frame_mux
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase,
  input  logic       cc_now,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  input  logic       fifo_last,
  output logic       fifo_rd,
  output logic [7:0] tx_char,
  output logic       tx_is_k
);
  logic       in_frame_q, in_frame_d;
  logic       eof_pend_q, eof_pend_d;
  logic [7:0] char_q, char_d;
  logic       k_q, k_d;
  logic       run;

  assign run = (phase == PH_RUN);

  always_comb begin
    in_frame_d = in_frame_q;
    eof_pend_d = eof_pend_q;
    fifo_rd    = 1'b0;
    char_d     = CH_IDLE;
    k_d        = 1'b1;
    if (!run) begin
      if (phase == PH_SYNC) begin
        char_d = CH_IDLE;
        k_d    = 1'b1;
      end else begin
        char_d = CH_QUIET;
        k_d    = 1'b0;
      end
    end else if (cc_now) begin
      char_d = CH_COMP;
    end else if (eof_pend_q) begin
      char_d     = CH_EOF;
      eof_pend_d = 1'b0;
      in_frame_d = 1'b0;
    end else if (!in_frame_q) begin
      if (!fifo_empty) begin
        char_d     = CH_SOF;
        in_frame_d = 1'b1;
      end
    end else if (!fifo_empty) begin
      char_d     = fifo_data;
      k_d        = 1'b0;
      fifo_rd    = 1'b1;
      eof_pend_d = fifo_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      eof_pend_q <= 1'b0;
      char_q     <= CH_QUIET;
      k_q        <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      eof_pend_q <= eof_pend_d;
      char_q     <= char_d;
      k_q        <= k_d;
    end
  end

  assign tx_char = char_q;
  assign tx_is_k = k_q;

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  // R5
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !tx_is_k);

  // R8
  cc_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cc_now) |=> (tx_is_k && tx_char == CH_COMP));

  // R6
  eof_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_is_k && tx_char == CH_EOF) |-> !in_frame_q);
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int RST_HOLD  = 3,
  parameter int SYNC_LEN  = 128,
  parameter int CC_PERIOD = 5000,
  parameter int CC_LEN    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  input  logic       fifo_last,
  output logic       fifo_rd,
  output logic [7:0] tx_char,
  output logic       tx_is_k
);
  logic   srst_n;
  phase_t phase;
  logic   cc_now;

  sertx_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sertx_init_seq #(
    .LANES    (LANES),
    .RST_HOLD (RST_HOLD),
    .SYNC_LEN (SYNC_LEN)
  ) u_init (
    .clk   (clk),
    .rst_n (srst_n),
    .phase (phase)
  );

  sertx_cc_timer #(
    .PERIOD (CC_PERIOD),
    .BURST  (CC_LEN)
  ) u_cc (
    .clk    (clk),
    .rst_n  (srst_n),
    .run    (phase == PH_RUN),
    .cc_now (cc_now)
  );

  sertx_frame_mux u_mux (
    .clk        (clk),
    .rst_n      (srst_n),
    .phase      (phase),
    .cc_now     (cc_now),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_last  (fifo_last),
    .fifo_rd    (fifo_rd),
    .tx_char    (tx_char),
    .tx_is_k    (tx_is_k)
  );
endmodule

// File: tb/sertx_framer_tb_top.sv
`timescale 1ns/100ps
module sertx_framer_tb_top;
  localparam int LANES = 2;
  localparam int RSTH  = 3;
  localparam int SYNC  = 8;
  localparam int PER   = 37;
  localparam int BUR   = 4;
  localparam int QUIET = 1 + (LANES + 2) + RSTH;
  localparam int NCYC  = 1400;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_last;
  logic       fifo_rd;
  logic [7:0] tx_char;
  logic       tx_is_k;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [8:0] q[$];

  always #2.5 clk = ~clk;

  sertx_framer #(
    .LANES(LANES), .RST_HOLD(RSTH), .SYNC_LEN(SYNC),
    .CC_PERIOD(PER), .CC_LEN(BUR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_rd(fifo_rd), .tx_char(tx_char), .tx_is_k(tx_is_k)
  );

  task automatic chk(input string tag, input bit ok, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_pkt(input int id, input int len);
    for (int i = 0; i < len; i++)
      q.push_back({(i == len - 1) ? 1'b1 : 1'b0, 8'((id * 37 + i * 11 + 5) & 255)});
  endtask

  initial begin
    bit         m_inf = 0, m_eof = 0;
    bit         stall;
    logic [7:0] e_ch;
    bit         e_k, e_rd;
    string      e_tag;

    rst_n = 1'b0;
    fifo_empty = 1'b1;
    fifo_data = 8'h00;
    fifo_last = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10", tx_char == 8'h00, "tx_char in reset", tx_char, 0);
    chk("R10", tx_is_k == 1'b0, "tx_is_k in reset", tx_is_k, 0);
    chk("R10", fifo_rd == 1'b0, "fifo_rd in reset", fifo_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    e_ch = 8'h00; e_k = 0; e_rd = 0; e_tag = "R1";
    for (int d = 0; d < NCYC; d++) begin
      @(negedge clk);
      if (d > 0) begin
        chk(e_tag, tx_char == e_ch, "tx_char", tx_char, e_ch);
        chk(e_tag, tx_is_k == e_k, "tx_is_k", tx_is_k, e_k);
        if (e_rd) void'(q.pop_front());
      end
      if (d == QUIET + SYNC + 20) begin
        push_pkt(1, 1); push_pkt(2, 2); push_pkt(3, 3);
        push_pkt(4, 40); push_pkt(5, 5); push_pkt(6, 1);
      end
      if (d == 500) begin
        push_pkt(7, 9); push_pkt(8, 17); push_pkt(9, 1); push_pkt(10, 60);
      end
      stall = (d >= 500) && (d % 7 == 3);
      fifo_empty = (q.size() == 0) || stall;
      fifo_data  = (q.size() == 0) ? 8'h00 : q[0][7:0];
      fifo_last  = (q.size() == 0) ? 1'b0  : q[0][8];
      #1;
      e_rd = 0;
      if (d < QUIET) begin
        e_ch = 8'h00; e_k = 0; e_tag = "R1";
      end else if (d < QUIET + SYNC) begin
        e_ch = 8'hBC; e_k = 1; e_tag = "R2";
      end else if (((d - QUIET - SYNC) % (PER + BUR)) >= PER) begin
        e_ch = 8'hFC; e_k = 1; e_tag = m_inf ? "R9" : "R8";
      end else if (m_eof) begin
        e_ch = 8'hFD; e_k = 1; e_tag = "R6"; m_eof = 0; m_inf = 0;
      end else if (!m_inf) begin
        if (!fifo_empty) begin
          e_ch = 8'hFB; e_k = 1; e_tag = "R4"; m_inf = 1;
        end else begin
          e_ch = 8'hBC; e_k = 1; e_tag = "R3";
        end
      end else if (!fifo_empty) begin
        e_ch = fifo_data; e_k = 0; e_rd = 1; e_tag = "R5"; m_eof = fifo_last;
      end else begin
        e_ch = 8'hBC; e_k = 1; e_tag = "R7";
      end
      chk((e_rd || e_tag == "R5") ? "R5" : "R9", fifo_rd == e_rd, "fifo_rd",
          fifo_rd, e_rd);
    end
    // R5: every pushed byte consumed exactly once
    chk("R5", q.size() == 0, "bytes left in FIFO", q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule